// File: doc/BRIEF.md
# Triple-Modulus Clock Divider

This block divides an input clock by 64, 65 or 72. Two select inputs choose the ratio. The divider has two parts:

- A small front counter that divides by four, or by five when it swallows one extra count.
- A five-bit step counter that advances once for each front-counter wrap, so it runs in lockstep with the front stage.

A synthesizer loop uses the block as its feedback prescaler. It steers the selects to interleave ratios and so reach fine frequency steps.

The select pair is captured once per output period, on the final input count. A change on the selects therefore applies whole to the next period and never to the one in progress.

The output is held low for the first 32 input clocks of every period. It is high from there to the period end. Its falling edge marks the period boundary.

Top module: `tri_mod_divider`

## Requirements
- R1: With sel_b=0 and sel_a=1, each output period lasts 64 input clocks: 32 low followed by 32 high.
- R2: With sel_b=0 and sel_a=0, each output period lasts 65 input clocks: 32 low followed by 33 high. The front counter spans five clocks only on the final step of the period.
- R3: With sel_b=1, each output period lasts 72 input clocks: 32 low followed by 40 high. The step counter runs through 18 states.
- R4: sel_b=1 selects 72 whatever the value of sel_a.
- R5: div_out rises after exactly 32 input clocks of a period have elapsed. It falls on the clock edge that ends the period.
- R6: The select inputs are sampled only at the period end. Select changes made inside a period, in either its low or its high phase, do not alter that period's length or duty.
- R7: A select change made during one period takes effect in the immediately following period, with no intervening mixed-length period.
- R8: A synchronous reset holds div_out low and loads the current select code. After reset is released, div_out first rises after 32 input clocks. Reset asserted mid-period restarts the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided; all state advances on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sel_a | input | 1 | Ratio select, low bit: 1 gives 64, 0 gives 65 (when sel_b=0) |
| sel_b | input | 1 | Ratio select, high bit: 1 forces 72 |
| div_out | output | 1 | Divided clock, low for 32 input clocks and then high until the period end |

## Verification
Select capture and the output fall share one clock edge. On that edge the period ends, the step counter wraps, and the code for the next period is latched. The bench drives every new code during the high phase of the period before it, so each new code lands on that shared edge. It then measures the very next period's low and high lengths in input clocks; a code applied one period late shows up as a wrong length. A separate directed case changes the code during a low phase. The bench then confirms that the running period keeps its old length and that the next period takes the new one.

// File: rtl/tmd_pkg.sv
package tmd_pkg;

   typedef enum logic [1:0] {
      RATIO_BASE    = 2'd0,
      RATIO_SWALLOW = 2'd1,
      RATIO_ALT     = 2'd2
   } ratio_e;

   // sel_b dominates; sel_a only chooses between base and swallow
   function automatic ratio_e decode_ratio(input logic sel_a, input logic sel_b);
      ratio_e r;
      if (sel_b)      r = RATIO_ALT;
      else if (sel_a) r = RATIO_BASE;
      else            r = RATIO_SWALLOW;
      return r;
   endfunction

endpackage

// File: rtl/tmd_front.sv
module tmd_front #(
   parameter int PRE_DIV = 4,
   parameter int PRE_W   = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             long_cycle,
   output logic             tick,
   output logic [PRE_W-1:0] phase
);
   localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_DIV - 1);
   localparam logic [PRE_W-1:0] PRE_MAX  = PRE_W'(PRE_DIV);

   logic [PRE_W-1:0] phase_q;

   assign tick  = (phase_q == (long_cycle ? PRE_MAX : PRE_LAST));
   assign phase = phase_q;

   always_ff @(posedge clk) begin
      if (rst)       phase_q <= '0;
      else if (tick) phase_q <= '0;
      else           phase_q <= phase_q + 1'b1;
   end

   // the extra front count only exists while the swallow step is active
   AST_LONG_ONLY_LAST: assert property (@(posedge clk) disable iff (rst)
      (phase_q == PRE_MAX) |-> long_cycle) else $error("extra front count outside swallow step"); // R2

endmodule

// File: rtl/tmd_back.sv
module tmd_back #(
   parameter int BACK_W = 5
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              step,
   input  logic [BACK_W-1:0] top_val,
   output logic              wrap,
   output logic [BACK_W-1:0] count
);
   logic [BACK_W-1:0] count_q;

   assign wrap  = (count_q == top_val);
   assign count = count_q;

   always_ff @(posedge clk) begin
      if (rst)              count_q <= '0;
      else if (step && wrap) count_q <= '0;
      else if (step)         count_q <= count_q + 1'b1;
   end

   AST_BACK_RANGE: assert property (@(posedge clk) disable iff (rst)
      count_q <= top_val) else $error("step counter beyond terminal"); // R3

endmodule

// File: rtl/tmd_ratio.sv
module tmd_ratio
   import tmd_pkg::*;
#(
   parameter int BASE_STEPS = 16,
   parameter int ALT_STEPS  = 18,
   parameter int BACK_W     = 5
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              sel_a,
   input  logic              sel_b,
   input  logic              period_end,
   input  logic [BACK_W-1:0] count,
   output logic              long_cycle,
   output logic [BACK_W-1:0] top_val
);
   localparam logic [BACK_W-1:0] BASE_LAST = BACK_W'(BASE_STEPS - 1);
   localparam logic [BACK_W-1:0] ALT_LAST  = BACK_W'(ALT_STEPS - 1);

   ratio_e ratio_q;

   // capture only at reset or at the boundary between periods
   always_ff @(posedge clk) begin
      if (rst || period_end) ratio_q <= decode_ratio(sel_a, sel_b);
   end

   assign long_cycle = (ratio_q == RATIO_SWALLOW) && (count == BASE_LAST);
   assign top_val    = (ratio_q == RATIO_ALT) ? ALT_LAST : BASE_LAST;

   AST_RATIO_HOLD: assert property (@(posedge clk) disable iff (rst)
      !period_end |=> $stable(ratio_q)) else $error("ratio changed inside a period"); // R6

endmodule

// File: rtl/tmd_wave.sv
module tmd_wave #(
   parameter int RISE_STEPS = 8,
   parameter int BACK_W     = 5
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              step,
   input  logic              period_end,
   input  logic [BACK_W-1:0] count,
   output logic              wave
);
   localparam logic [BACK_W-1:0] RISE_LAST = BACK_W'(RISE_STEPS - 1);

   logic wave_q;

   always_ff @(posedge clk) begin
      if (rst || period_end)               wave_q <= 1'b0;
      else if (step && count == RISE_LAST) wave_q <= 1'b1;
   end

   assign wave = wave_q;

endmodule

// File: rtl/tri_mod_divider.sv
module tri_mod_divider #(
   parameter int PRE_DIV    = 4,
   parameter int BASE_STEPS = 16,
   parameter int ALT_STEPS  = 18,
   parameter int RISE_STEPS = 8
) (
   input  logic clk,
   input  logic rst,
   input  logic sel_a,
   input  logic sel_b,
   output logic div_out
);
   localparam int PRE_W  = $clog2(PRE_DIV + 1);
   localparam int BACK_W = $clog2(ALT_STEPS > BASE_STEPS ? ALT_STEPS : BASE_STEPS);
   localparam logic [BACK_W-1:0] RISE_AT = BACK_W'(RISE_STEPS);

   // elaboration-time parameter checks
   generate
      if (PRE_DIV < 2) begin : g_bad_pre
         $error("PRE_DIV must be at least 2");
      end
      if (BASE_STEPS < 2 || ALT_STEPS < 2) begin : g_bad_steps
         $error("step counts must be at least 2");
      end
      if (RISE_STEPS < 1 || RISE_STEPS >= BASE_STEPS || RISE_STEPS >= ALT_STEPS) begin : g_bad_rise
         $error("RISE_STEPS must fall inside both step ranges");
      end
   endgenerate

   logic              tick;
   logic              wrap;
   logic              long_cycle;
   logic              period_end;
   logic [PRE_W-1:0]  phase;
   logic [BACK_W-1:0] count;
   logic [BACK_W-1:0] top_val;

   assign period_end = tick && wrap;

   tmd_front #(.PRE_DIV(PRE_DIV), .PRE_W(PRE_W)) u_front (
      .clk(clk), .rst(rst), .long_cycle(long_cycle), .tick(tick), .phase(phase)
   );

   tmd_back #(.BACK_W(BACK_W)) u_back (
      .clk(clk), .rst(rst), .step(tick), .top_val(top_val), .wrap(wrap), .count(count)
   );

   tmd_ratio #(.BASE_STEPS(BASE_STEPS), .ALT_STEPS(ALT_STEPS), .BACK_W(BACK_W)) u_ratio (
      .clk(clk), .rst(rst), .sel_a(sel_a), .sel_b(sel_b), .period_end(period_end),
      .count(count), .long_cycle(long_cycle), .top_val(top_val)
   );

   tmd_wave #(.RISE_STEPS(RISE_STEPS), .BACK_W(BACK_W)) u_wave (
      .clk(clk), .rst(rst), .step(tick), .period_end(period_end), .count(count), .wave(div_out)
   );

   AST_FALL_AT_END: assert property (@(posedge clk) disable iff (rst)
      period_end |=> !div_out) else $error("output high after period end"); // R5
   AST_RISE_POSITION: assert property (@(posedge clk) disable iff (rst)
      $rose(div_out) |-> (count == RISE_AT && phase == '0)) else $error("output rose off position"); // R5
   AST_WRAP_TO_START: assert property (@(posedge clk) disable iff (rst)
      period_end |=> (count == '0 && phase == '0)) else $error("period did not restart"); // R7
   AST_RESET_CLEAR: assert property (@(posedge clk)
      rst |=> (!div_out && count == '0 && phase == '0)) else $error("reset did not clear"); // R8

endmodule

// File: tb/tb_tri_mod_divider.sv
`timescale 1ns/1ps
module tb_tri_mod_divider;

   logic clk = 1'b0;
   logic rst;
   logic sel_a;
   logic sel_b;
   logic div_out;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   tri_mod_divider dut (.clk(clk), .rst(rst), .sel_a(sel_a), .sel_b(sel_b), .div_out(div_out));

   // {sel_a, sel_b, expected period}; each entry is driven during the previous period's high phase
   localparam int NV = 10;
   localparam int VEC [NV][3] = '{
      '{1, 0, 64}, '{0, 0, 65}, '{1, 0, 64}, '{0, 0, 65}, '{0, 1, 72},
      '{1, 1, 72}, '{0, 0, 65}, '{1, 1, 72}, '{1, 0, 64}, '{0, 1, 72}
   };

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // entered on the first low sample of a period; leaves on the first low sample of the next
   task automatic measure(output int lo, output int hi, input bit drive, input logic na, input logic nb);
      lo = 1;
      forever begin
         @(negedge clk);
         if (div_out) break;
         lo++;
      end
      hi = 1;
      if (drive) begin
         sel_a = na;
         sel_b = nb;
      end
      forever begin
         @(negedge clk);
         if (!div_out) break;
         hi++;
      end
   endtask

   task automatic count_to_rise(output int n, input bit poke);
      n = 0;
      forever begin
         @(posedge clk);
         n++;
         @(negedge clk);
         if (poke && n == 5) sel_b = 1'b1;   // mid-low change, must not affect this period
         if (div_out) break;
      end
   endtask

   task automatic count_high(output int n);
      n = 1;
      forever begin
         @(negedge clk);
         if (!div_out) break;
         n++;
      end
   endtask

   initial begin
      #(4 * 150000);
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int lo, hi, n;
      rst = 1'b1; sel_a = 1'b1; sel_b = 1'b0;
      repeat (3) @(negedge clk);
      chk("R8 reset output", int'(div_out), 0);
      rst = 1'b0;

      // R8: first rise after 32 clocks; R6: sel_b raised during low phase is ignored
      count_to_rise(n, 1'b1);
      chk("R8 first rise", n, 32);
      count_high(n);
      chk("R6 high after mid-low change", n, 32);

      // R7: the latched 72 applies to the very next period
      measure(lo, hi, 1'b1, 1'(VEC[0][0]), 1'(VEC[0][1]));
      chk("R7 low after switch", lo, 32);
      chk("R3 high for 72", hi, 40);

      // table walk: back-to-back ratio switches (R1 R2 R3 R4 R5 R7)
      for (int i = 0; i < NV; i++) begin
         int j;
         j = (i + 1 < NV) ? i + 1 : i;
         measure(lo, hi, 1'b1, 1'(VEC[j][0]), 1'(VEC[j][1]));
         chk("R5 low phase", lo, 32);
         if (VEC[i][2] == 64)      chk("R1 high for 64", hi, 32);
         else if (VEC[i][2] == 65) chk("R2 high for 65", hi, 33);
         else if (VEC[i][0] == 1)  chk("R4 high for 72 with sel_a set", hi, 40);
         else                      chk("R3 high for 72", hi, 40);
      end

      // R8: mid-period reset restarts; reset loads code 72 (R4 with sel_a=1)
      sel_a = 1'b0; sel_b = 1'b0;
      repeat (10) @(negedge clk);
      rst = 1'b1; sel_a = 1'b1; sel_b = 1'b1;
      repeat (2) @(negedge clk);
      chk("R8 output low in reset", int'(div_out), 0);
      rst = 1'b0;
      count_to_rise(n, 1'b0);
      chk("R8 rise after mid-period reset", n, 32);
      count_high(n);
      chk("R8 reset-loaded 72 high", n, 40);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule